// File: doc/BRIEF.md
# Single-Word PHY Management Controller

This block lets software run one management transaction on an MDIO-style two-wire bus to external PHYs through a single 32-bit command/status word. One write to that word carries the whole transaction: the direction, the PHY address, the PHY register number and, for a write, the 16 data bits. The block then produces the management clock from the system clock and shifts out a complete frame. For a read it releases the data line and captures the PHY's answer.

Reading the word at any time returns the fields of the last accepted command, a busy flag while the frame runs and a read-valid flag once read data sits in the low half. Software polls busy, then collects read data from the same word. The register port is a plain write strobe with a data bus plus an always-valid read bus. There is no back-pressure: a write that arrives while busy is dropped. The management bus pins are plain control pins.

Top module: `phy_mgmt_ctrl`

## Requirements
- R1: After reset the word reads as all zeros, MDC is low and the MDIO output enable is low.
- R2: Command word layout: bit 26 = direction (1 read, 0 write), bits 25:21 = PHY register number, bits 20:16 = PHY address, bits 15:0 = write data. After a command is accepted, these bit positions read back with the accepted values. Bits 31:29 read as zero.
- R3: Bit 28 (busy) reads 1 from the clock after a command is accepted until the frame's last MDC period ends. It then returns to 0.
- R4: A write frame, taken from MDIO on MDC rising edges, is 64 bits with MSB first: 32 ones, 01, 01, 5-bit PHY address, 5-bit register number, 10, then the 16 data bits. The output is driven for all 64 bits.
- R5: A read frame is 32 ones, 01, 10, PHY address and register number as in R4. The output enable is low for the last 18 MDC periods: the two turnaround bits and the 16 data bits.
- R6: In a read, MDIO is sampled on each MDC rising edge of periods 48 to 63. The sampled value goes into bits 15:0 MSB first, and bit 27 (read-valid) sets when busy clears.
- R7: Accepting a new command clears read-valid on the next clock.
- R8: A write to the word while busy is set is ignored. The frame in flight and every readable field stay as they were.
- R9: MDC is low whenever the block is idle. While busy, each MDC half-period lasts DIV_HALF system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the command word |
| reg_wdata | input | 32 | Command word written by software |
| reg_rdata | output | 32 | Current command/status word |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | MDIO value driven by this block |
| mdio_oe | output | 1 | MDIO output enable (0 = released) |
| mdio_i | input | 1 | MDIO value seen on the pin |

## Verification
The bench sends random reads and writes with random PHY address, register and data values, plus directed all-ones and all-zeros data words. A captured frame is compared bit by bit with one the bench builds itself, which separates a wrong field order, a wrong opcode or turnaround from a wrong data shift. For reads, a bench PHY model drives chosen data words in the released window, so a sample taken on the wrong edge or a bit that is off by one shows up in the returned word. A second command issued mid-frame shows whether a busy-time write can reach the frame or the readable fields. A measurement of the MDC rising-edge spacing checks the divider.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam int FRAME_BITS = 64;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam int TA_IDX     = 46;   // first turnaround period
  localparam int DATA_IDX   = 48;   // first data period

  typedef struct packed {
    logic        is_read;
    logic [4:0]  regad;
    logic [4:0]  phyad;
    logic [15:0] data;
  } mgmt_cmd_t;

  function automatic logic [FRAME_BITS-1:0] make_frame(input mgmt_cmd_t c);
    logic [1:0] opc;
    logic [1:0] ta;
    opc = c.is_read ? 2'b10 : 2'b01;
    ta  = c.is_read ? 2'b11 : 2'b10;
    return {32'hFFFF_FFFF, 2'b01, opc, c.phyad, c.regad, ta,
            c.is_read ? 16'hFFFF : c.data};
  endfunction
endpackage

// File: rtl/mgmt_mdc_gen.sv
module mgmt_mdc_gen #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int DW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV_HALF - 1);

  logic [DW-1:0] cnt;
  logic          wrap;

  assign wrap      = run && (cnt == LAST);
  assign rise_tick = wrap && !mdc;
  assign fall_tick = wrap && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mgmt_frame_eng.sv
module mgmt_frame_eng
  import mgmt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] frame_in,
  input  logic                  is_read,
  input  logic                  rise_tick,
  input  logic                  fall_tick,
  input  logic                  mdio_i,
  output logic                  active,
  output logic                  done,
  output logic [15:0]           rd_data,
  output logic                  mdio_o,
  output logic                  mdio_oe
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] shreg;
  logic [CNT_W-1:0]      bitcnt;
  logic                  rd;

  assign done    = active && fall_tick && (bitcnt == LAST_BIT);
  assign mdio_o  = shreg[FRAME_BITS-1];
  assign mdio_oe = active && !(rd && (bitcnt >= CNT_W'(TA_IDX)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bitcnt  <= '0;
      rd      <= 1'b0;
      active  <= 1'b0;
      rd_data <= '0;
    end else if (start) begin
      shreg   <= frame_in;
      bitcnt  <= '0;
      rd      <= is_read;
      active  <= 1'b1;
      rd_data <= '0;
    end else if (active) begin
      if (rise_tick && rd && (bitcnt >= CNT_W'(DATA_IDX)))
        rd_data <= {rd_data[14:0], mdio_i};
      if (fall_tick) begin
        if (bitcnt == LAST_BIT) begin
          active <= 1'b0;
        end else begin
          shreg  <= {shreg[FRAME_BITS-2:0], 1'b1};
          bitcnt <= bitcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/phy_mgmt_ctrl.sv
module phy_mgmt_ctrl
  import mgmt_pkg::*;
#(
  parameter int DIV_HALF = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  mgmt_cmd_t cmd_q;
  mgmt_cmd_t cmd_new;
  logic      rvalid;
  logic      busy;
  logic      accept;
  logic      rise_tick, fall_tick, done;
  logic [15:0] rd_data;
  logic      unused_hi;

  assign unused_hi = ^reg_wdata[31:27];
  assign cmd_new   = mgmt_cmd_t'(reg_wdata[26:0]);
  assign accept    = reg_wr && !busy;
  assign reg_rdata = {3'b000, busy, rvalid, cmd_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      rvalid <= 1'b0;
    end else if (accept) begin
      cmd_q  <= cmd_new;
      rvalid <= 1'b0;
    end else if (done && cmd_q.is_read) begin
      cmd_q.data <= rd_data;
      rvalid     <= 1'b1;
    end
  end

  mgmt_mdc_gen #(.DIV_HALF(DIV_HALF)) u_mdc (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mgmt_frame_eng u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .frame_in  (make_frame(cmd_new)),
    .is_read   (cmd_new.is_read),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdio_i    (mdio_i),
    .active    (busy),
    .done      (done),
    .rd_data   (rd_data),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
  );
endmodule

// File: rtl/mgmt_chk.sv
module mgmt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [31:0] reg_rdata,
  input logic        mdc,
  input logic        mdio_oe
);
  logic busy_s, rv_s, rd_s;
  assign busy_s = reg_rdata[28];
  assign rv_s   = reg_rdata[27];
  assign rd_s   = reg_rdata[26];

  AST_BUSY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && !busy_s |=> busy_s) else $error("busy did not set"); // R3
  AST_RVALID_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && !busy_s |=> !rv_s) else $error("read-valid kept"); // R7
  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_s |-> !mdc) else $error("mdc toggling while idle"); // R9
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_s |-> !mdio_oe) else $error("mdio driven while idle"); // R1
  AST_WRITE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_s && !rd_s |-> mdio_oe) else $error("write frame released"); // R4
  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_s && reg_wr |=> $stable(reg_rdata[26:16])) else $error("fields changed"); // R8
  AST_RVALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rv_s |-> !busy_s) else $error("valid while busy"); // R6
endmodule

bind phy_mgmt_ctrl mgmt_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_rdata (reg_rdata),
  .mdc       (mdc),
  .mdio_oe   (mdio_oe)
);

// File: tb/sim_phy_mgmt_ctrl.sv
module sim_phy_mgmt_ctrl;
  localparam int DIV_HALF = 2;
  localparam int MAX_CYC  = 64 * 2 * DIV_HALF + 20;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, mdio_i = 1'b1;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mdc, mdio_o, mdio_oe;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  phy_mgmt_ctrl #(.DIV_HALF(DIV_HALF)) u0 (.*);

  // bench PHY model and frame capture
  int          idx;
  logic        phy_rd;
  logic [15:0] phy_data;
  logic [63:0] cap_v, cap_oe;

  always @(posedge mdc) begin
    if (idx >= 0 && idx < 64) begin
      cap_v[63-idx]  = mdio_oe ? mdio_o : 1'b0;
      cap_oe[63-idx] = mdio_oe;
    end
  end
  always @(negedge mdc) begin
    idx = idx + 1;
    mdio_i <= (phy_rd && idx >= 48 && idx <= 63) ? phy_data[63-idx] : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] ph,
                                            input logic [4:0] rg, input logic [15:0] d);
    logic [63:0] f;
    f = '1;
    f[31:30] = 2'b01;
    f[29:28] = rd ? 2'b10 : 2'b01;
    f[27:23] = ph;
    f[22:18] = rg;
    f[17:16] = 2'b10;
    f[15:0]  = d;
    return f;
  endfunction

  function automatic logic [63:0] exp_oe(input bit rd);
    return rd ? {{46{1'b1}}, 18'b0} : '1;
  endfunction

  task automatic issue(input logic [31:0] w);
    @(negedge clk);
    reg_wdata = w; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic run_cmd(input bit rd, input logic [4:0] ph, input logic [4:0] rg,
                         input logic [15:0] d, input logic [15:0] pd);
    logic [63:0] ef, em;
    int n;
    phy_rd = rd; phy_data = pd; idx = 0; cap_v = '0; cap_oe = '0; mdio_i = 1'b1;
    issue({5'b0, rd, rg, ph, d});
    chk(reg_rdata[28] === 1'b1 && reg_rdata[27] === 1'b0, "R3/R7 busy set, valid clear",
        64'(reg_rdata), 64'h1000_0000);
    chk(reg_rdata[26:0] === {rd, rg, ph, d}, "R2 field readback",
        64'(reg_rdata[26:0]), 64'({rd, rg, ph, d}));
    n = 0;
    while (reg_rdata[28] && n < MAX_CYC) begin @(negedge clk); n++; end
    chk(n < MAX_CYC && n > 60 * 2 * DIV_HALF, "R3 busy duration", 64'(n), 64'(64 * 2 * DIV_HALF));
    ef = exp_frame(rd, ph, rg, rd ? 16'h0 : d);
    em = exp_oe(rd);
    chk((cap_v & em) === (ef & em), rd ? "R5 read frame" : "R4 write frame", cap_v & em, ef & em);
    chk(cap_oe === em, rd ? "R5 release window" : "R4 driven", cap_oe, em);
    if (rd)
      chk(reg_rdata[27] === 1'b1 && reg_rdata[15:0] === pd, "R6 read data",
          64'(reg_rdata[27:0]), 64'({1'b1, 1'b1, rg, ph, pd}));
    chk(mdc === 1'b0, "R9 mdc idle low", 64'(mdc), 64'd0);
  endtask

  initial begin
    int prev_rise, cnt, gap;
    logic pm;
    repeat (3) @(negedge clk);
    chk(reg_rdata === 32'h0 && mdc === 1'b0 && mdio_oe === 1'b0, "R1 reset state",
        64'(reg_rdata), 64'd0);
    rst_n = 1'b1;
    void'($urandom(32'd1234));

    // directed corners
    run_cmd(1'b0, 5'h1F, 5'h00, 16'hFFFF, 16'h0);
    run_cmd(1'b1, 5'h00, 5'h1F, 16'h0, 16'hFFFF);
    run_cmd(1'b1, 5'h15, 5'h0A, 16'h0, 16'h0000);
    run_cmd(1'b1, 5'h03, 5'h11, 16'h0, 16'h8001);

    // R7: a write after a completed read clears read-valid
    run_cmd(1'b0, 5'h02, 5'h04, 16'h1234, 16'h0);
    chk(reg_rdata[27] === 1'b0, "R7 valid cleared by new command", 64'(reg_rdata[27]), 64'd0);

    // random transactions
    for (int i = 0; i < 10; i++) begin
      logic [31:0] r;
      r = $urandom;
      run_cmd(r[31], r[4:0], r[9:5], r[25:10], $urandom);
    end

    // R9: MDC period measurement; R8: write while busy
    phy_rd = 1'b0; idx = 0; cap_v = '0; cap_oe = '0;
    issue({5'b0, 1'b0, 5'h05, 5'h09, 16'hA5C3});
    pm = mdc; cnt = 0; prev_rise = -1; gap = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); cnt++;
      if (!pm && mdc) begin
        if (prev_rise >= 0) gap = cnt - prev_rise;
        prev_rise = cnt;
      end
      pm = mdc;
    end
    chk(gap == 2 * DIV_HALF, "R9 mdc period", 64'(gap), 64'(2 * DIV_HALF));
    issue({5'b0, 1'b1, 5'h1A, 5'h16, 16'h0F0F});
    chk(reg_rdata[26:0] === {1'b0, 5'h05, 5'h09, 16'hA5C3}, "R8 fields unchanged",
        64'(reg_rdata[26:0]), 64'({1'b0, 5'h05, 5'h09, 16'hA5C3}));
    begin
      int n = 0;
      while (reg_rdata[28] && n < MAX_CYC) begin @(negedge clk); n++; end
    end
    chk(cap_v === exp_frame(1'b0, 5'h09, 5'h05, 16'hA5C3) && cap_oe === '1,
        "R8 frame unchanged", cap_v, exp_frame(1'b0, 5'h09, 5'h05, 16'hA5C3));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule